// File: doc/BRIEF.md
# Parity-Protected Write-Through Data Cache

This block is a small direct-mapped data cache placed between a processor load/store port and a word-wide memory port. Every store goes on to memory, so memory always holds a good copy of every cached word and no line ever needs a dirty bit. Each stored data word carries one even-parity bit. The parity bit is generated whenever the word is written into the data array and is checked on every load hit. If a load hits a valid line but the selected word fails its parity check, the access is handled as a miss. The whole line is fetched again from memory and the fresh word is returned, so corrupted data never reaches the processor. A saturating counter records how many loads were recovered this way.

A store to a line that is not resident first fetches the full line. It then merges the store word into the cached line and sends that word to memory. Stores are whole words only. The processor holds `cpu_req` with a stable address and data until it sees a one-cycle `cpu_ready` pulse. A new request is not taken while a refill or a write-through is in progress. A fault-injection input flips one stored data bit, which lets a test drive the parity recovery path.

The controller has six states:
- IDLE waits for a request.
- LOOKUP compares the tag and checks parity.
- FILL_REQ issues one line-beat read.
- FILL_RSP waits for the read data and writes it into the array.
- WT_REQ issues the write-through.
- DONE pulses ready.

Transitions:
- IDLE→LOOKUP on a request.
- LOOKUP→DONE on a clean load hit.
- LOOKUP→WT_REQ on a store hit.
- LOOKUP→FILL_REQ on any miss, including a parity-forced miss.
- FILL_REQ→FILL_RSP when memory accepts the read.
- FILL_RSP→FILL_REQ after an intermediate beat.
- FILL_RSP→LOOKUP after the last beat, which re-runs the lookup on the freshly filled line.
- WT_REQ→DONE when memory accepts the write.
- DONE→IDLE.

Top module: `wt_parity_dcache`

## Requirements
- R1: After reset, all lines are invalid, `err_count` is 0, and `cpu_ready` and `mem_req_valid` are low. The first load to any address therefore misses.
- R2: The byte address splits as follows: bits [1:0] are ignored, bits [3:2] select the word in the line, bits [7:4] select the line, and bits [31:8] form the tag. Two addresses with the same line bits and different tags evict each other.
- R3: A load that hits with correct parity returns the stored word with no memory request.
- R4: A load miss fetches the line as 4 single-word reads (`mem_req_we`=0) at word offsets 0,1,2,3 of the line-aligned address, then returns the requested word.
- R5: Every store causes exactly one memory write (`mem_req_we`=1) of the store data at the word-aligned address. `cpu_ready` for a store comes only after memory has accepted that write.
- R6: A store miss first fetches the whole line (4 reads), then merges the store word into the cache, then writes it to memory. Later loads to the line hit and return the memory values for the other words and the stored value for the merged word.
- R7: Each data word is stored with an even-parity bit. A load hit whose selected word fails parity is treated as a miss, refills the line and returns the memory value. Parity faults in words that are not selected do not affect the access.
- R8: Every parity-forced miss adds one to `err_count`, which saturates at 255.
- R9: `cpu_ready` is high for exactly one cycle per accepted request.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with unchanged address, direction and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = word write, 0 = word read |
| mem_req_addr | output | 32 | Word-aligned memory byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data beat valid |
| mem_rsp_data | input | 32 | Read data beat |
| err_count | output | 8 | Saturating parity-forced miss count |
| inj_en | input | 1 | Flip one stored data bit this cycle |
| inj_idx | input | 4 | Line of the bit to flip |
| inj_word | input | 2 | Word of the bit to flip |
| inj_bit | input | 5 | Bit position to flip |

## Verification
The hardest case to reach from the ports is a load that hits a valid line whose selected word has bad parity. Normal traffic always stores good parity. The bench therefore pulses the injection input while the cache is idle, to flip one bit of a resident word. It then loads that word and confirms the correct memory value, four refill reads and one more error count. It also corrupts a neighbouring word and shows that a load of a clean word still hits. Repeating the corruption and load several hundred times drives the counter into saturation.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL_REQ,
        ST_FILL_RSP,
        ST_WT_REQ,
        ST_DONE
    } wtc_state_e;

endpackage

// File: rtl/wtc_arrays.sv
module wtc_arrays #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 24,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS),
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    // lookup port
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_word,
    output logic              rd_par,
    // data write port
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    // tag install
    input  logic              tag_set,
    input  logic [TAG_W-1:0]  tag_val,
    // fault injection
    input  logic              inj_en,
    input  logic [IDX_W-1:0]  inj_idx,
    input  logic [OFF_W-1:0]  inj_word,
    input  logic [BIT_W-1:0]  inj_bit
);

    logic [DATA_W:0]   data_q  [LINES][WORDS];
    logic              valid_q [LINES];
    logic [TAG_W-1:0]  tag_q   [LINES];
    logic              any_valid;

    // per-line valid and tag registers
    for (genvar l = 0; l < LINES; l++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[l] <= 1'b0;
                tag_q[l]   <= '0;
            end else if (tag_set && (wr_idx == IDX_W'(l))) begin
                valid_q[l] <= 1'b1;
                tag_q[l]   <= tag_val;
            end
        end
    end

    // data words with even parity in the top bit
    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_idx][wr_off] <= {^wr_data, wr_data};
        end else if (inj_en) begin
            data_q[inj_idx][inj_word] <= data_q[inj_idx][inj_word]
                ^ ((DATA_W+1)'(1) << inj_bit);
        end
    end

    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_word  = data_q[rd_idx][rd_off][DATA_W-1:0];
        rd_par   = data_q[rd_idx][rd_off][DATA_W];
    end

    always_comb begin
        any_valid = 1'b0;
        for (int l = 0; l < LINES; l++) any_valid = any_valid | valid_q[l];
    end

    // R1: no line is valid right after reset release
    p_clear_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !any_valid);

    // R7: every word written lands with even overall parity
    p_write_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (^data_q[$past(wr_idx)][$past(wr_off)]) == 1'b0);

endmodule

// File: rtl/wtc_errcnt.sv
module wtc_errcnt #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ERR_W-1:0] count
);

    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      count <= '0;
        else if (inc && count != CNT_MAX) count <= count + 1'b1;
    end

    // R8: the counter stays at its ceiling
    p_err_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX) |=> (count == CNT_MAX));

    // R8: the counter never moves without a parity-forced miss
    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count));

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int LINES  = 16,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int IDX_W  = $clog2(LINES),
    localparam int BYTE_W = $clog2(DATA_W/8),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W,
    localparam int WA_W   = ADDR_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    // processor side
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    // memory side
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    // array side
    output logic [IDX_W-1:0]  lk_idx,
    output logic [OFF_W-1:0]  lk_off,
    input  logic              lk_valid,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [DATA_W-1:0] lk_word,
    input  logic              lk_par,
    output logic              wr_en,
    output logic [OFF_W-1:0]  wr_off,
    output logic [DATA_W-1:0] wr_data,
    output logic              tag_set,
    output logic [TAG_W-1:0]  tag_val,
    // error event
    output logic              par_err
);

    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

    wtc_state_e        state_q, state_d;
    logic [WA_W-1:0]   waddr_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [OFF_W-1:0]  beat_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rpar_q;

    logic [TAG_W-1:0]  tag_q;
    logic              hit;
    logic              par_ok;
    logic              last_beat;

    assign tag_q     = waddr_q[WA_W-1 -: TAG_W];
    assign lk_idx    = waddr_q[OFF_W +: IDX_W];
    assign lk_off    = waddr_q[OFF_W-1:0];
    assign hit       = lk_valid && (lk_tag == tag_q);
    assign par_ok    = ((^lk_word) ^ lk_par) == 1'b0;
    assign last_beat = (beat_q == LAST_BEAT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cpu_req) state_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (we_q)              state_d = hit ? ST_WT_REQ : ST_FILL_REQ;
                else if (hit && par_ok) state_d = ST_DONE;
                else                   state_d = ST_FILL_REQ;
            end
            ST_FILL_REQ: if (mem_req_ready) state_d = ST_FILL_RSP;
            ST_FILL_RSP: if (mem_rsp_valid) state_d = last_beat ? ST_LOOKUP : ST_FILL_REQ;
            ST_WT_REQ:   if (mem_req_ready) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // request capture, beat counter, load data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waddr_q <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            beat_q  <= '0;
            rdata_q <= '0;
            rpar_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (cpu_req) begin
                    waddr_q <= cpu_addr[ADDR_W-1:BYTE_W];
                    we_q    <= cpu_we;
                    wdata_q <= cpu_wdata;
                end
                ST_LOOKUP: begin
                    beat_q <= '0;
                    if (!we_q && hit && par_ok) begin
                        rdata_q <= lk_word;
                        rpar_q  <= lk_par;
                    end
                end
                ST_FILL_RSP: if (mem_rsp_valid) beat_q <= beat_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cpu_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        wr_en         = 1'b0;
        wr_off        = beat_q;
        wr_data       = mem_rsp_data;
        tag_set       = 1'b0;
        tag_val       = tag_q;
        par_err       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOOKUP: begin
                if (we_q && hit) begin
                    wr_en   = 1'b1;
                    wr_off  = lk_off;
                    wr_data = wdata_q;
                end
                par_err = !we_q && hit && !par_ok;
            end
            ST_FILL_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {tag_q, lk_idx, beat_q, {BYTE_W{1'b0}}};
            end
            ST_FILL_RSP: begin
                wr_en   = mem_rsp_valid;
                tag_set = mem_rsp_valid && last_beat;
            end
            ST_WT_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = {waddr_q, {BYTE_W{1'b0}}};
                mem_req_wdata = wdata_q;
            end
            ST_DONE: cpu_ready = 1'b1;
            default: ;
        endcase
    end

    assign cpu_rdata = rdata_q;

    // R9: completion is a single-cycle pulse
    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R10: a stalled memory request is held unchanged
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)
             && $stable(mem_req_wdata)));

    // R7: load data handed back always carries consistent parity
    p_good_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !we_q) |-> (((^rdata_q) ^ rpar_q) == 1'b0));

    // R5: write-through carries the processor's store word for the pending store
    p_wt_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |->
            (cpu_req && cpu_we && mem_req_wdata == cpu_wdata));

endmodule

// File: rtl/wt_parity_dcache.sv
module wt_parity_dcache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int LINES  = 16,
    parameter int ERR_W  = 8,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int IDX_W  = $clog2(LINES),
    localparam int BYTE_W = $clog2(DATA_W/8),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W,
    localparam int BIT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic [ERR_W-1:0]  err_count,
    input  logic              inj_en,
    input  logic [IDX_W-1:0]  inj_idx,
    input  logic [OFF_W-1:0]  inj_word,
    input  logic [BIT_W-1:0]  inj_bit
);

    logic [IDX_W-1:0]  lk_idx;
    logic [OFF_W-1:0]  lk_off;
    logic              lk_valid;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] lk_word;
    logic              lk_par;
    logic              wr_en;
    logic [OFF_W-1:0]  wr_off;
    logic [DATA_W-1:0] wr_data;
    logic              tag_set;
    logic [TAG_W-1:0]  tag_val;
    logic              par_err;

    wtc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req       (cpu_req),
        .cpu_we        (cpu_we),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cpu_ready     (cpu_ready),
        .cpu_rdata     (cpu_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .lk_idx        (lk_idx),
        .lk_off        (lk_off),
        .lk_valid      (lk_valid),
        .lk_tag        (lk_tag),
        .lk_word       (lk_word),
        .lk_par        (lk_par),
        .wr_en         (wr_en),
        .wr_off        (wr_off),
        .wr_data       (wr_data),
        .tag_set       (tag_set),
        .tag_val       (tag_val),
        .par_err       (par_err)
    );

    wtc_arrays #(
        .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) u_arrays (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_off   (lk_off),
        .rd_valid (lk_valid),
        .rd_tag   (lk_tag),
        .rd_word  (lk_word),
        .rd_par   (lk_par),
        .wr_en    (wr_en),
        .wr_idx   (lk_idx),
        .wr_off   (wr_off),
        .wr_data  (wr_data),
        .tag_set  (tag_set),
        .tag_val  (tag_val),
        .inj_en   (inj_en),
        .inj_idx  (inj_idx),
        .inj_word (inj_word),
        .inj_bit  (inj_bit)
    );

    wtc_errcnt #(.ERR_W(ERR_W)) u_errcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (par_err),
        .count (err_count)
    );

endmodule

// File: tb/wt_parity_dcache_bench.sv
module wt_parity_dcache_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req_valid, mem_req_we;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_ready = 1'b1;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic [7:0]  err_count;
    logic        inj_en = 1'b0;
    logic [3:0]  inj_idx = '0;
    logic [1:0]  inj_word = '0;
    logic [4:0]  inj_bit = '0;

    always #2 clk = ~clk;  // 250 MHz

    wt_parity_dcache u_wt_parity_dcache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .err_count(err_count),
        .inj_en(inj_en), .inj_idx(inj_idx), .inj_word(inj_word), .inj_bit(inj_bit)
    );

    // ---------------- memory model (golden storage) ----------------
    logic [31:0] bmem [1024];
    bit          slow = 1'b0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [31:0] rd_addr_log [4];
    int          rd_addr_ok = 1;

    initial for (int i = 0; i < 1024; i++) bmem[i] = (i * 32'h9E3779B1) ^ 32'hC0DE0000;

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_ready     <= slow ? ~mem_ready : 1'b1;
        if (mem_req_valid && mem_ready) begin
            if (mem_req_we) begin
                bmem[mem_req_addr[11:2]] <= mem_req_wdata;
                wr_cnt = wr_cnt + 1;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= bmem[mem_req_addr[11:2]];
                rd_addr_log[rd_cnt % 4] = mem_req_addr;
                rd_cnt = rd_cnt + 1;
            end
        end
    end

    // ready pulse width monitor
    int ready_run = 0, ready_max = 0;
    always @(negedge clk) begin
        if (cpu_ready) ready_run = ready_run + 1; else ready_run = 0;
        if (ready_run > ready_max) ready_max = ready_run;
    end

    // ---------------- checking ----------------
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        int n;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        n = 0;
        do begin @(negedge clk); n++; end while (!cpu_ready && n < 500);
        rd = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic inject(input logic [3:0] idx, input logic [1:0] w, input logic [4:0] b);
        @(negedge clk);
        inj_en = 1'b1; inj_idx = idx; inj_word = w; inj_bit = b;
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    function automatic logic [31:0] gold(input logic [31:0] a);
        return bmem[a[11:2]];
    endfunction

    int exp_err = 0;

    task automatic t_reset();
        chk("R1 ready after reset", {31'b0, cpu_ready}, 32'd0);
        chk("R1 mem valid after reset", {31'b0, mem_req_valid}, 32'd0);
        chk("R1 err_count after reset", {24'b0, err_count}, 32'd0);
    endtask

    task automatic t_cold_load();
        logic [31:0] rd; int r0 = rd_cnt;
        access(0, 32'h0000_0108, 0, rd);
        chk("R1 cold load misses (reads)", rd_cnt - r0, 4);
        chk("R4 refill data", rd, gold(32'h108));
        for (int k = 0; k < 4; k++)
            chk("R4 refill beat address", rd_addr_log[(r0 + k) % 4], 32'h100 + 4*k);
    endtask

    task automatic t_hits();
        logic [31:0] rd; int r0 = rd_cnt;
        access(0, 32'h0000_0104, 0, rd);
        chk("R3 hit data", rd, gold(32'h104));
        access(0, 32'h0000_0107, 0, rd);
        chk("R2 byte bits ignored", rd, gold(32'h104));
        access(0, 32'h0000_010C, 0, rd);
        chk("R3 hit data last word", rd, gold(32'h10C));
        chk("R3 hits make no reads", rd_cnt - r0, 0);
    endtask

    task automatic t_store_hit();
        logic [31:0] rd; int r0 = rd_cnt, w0 = wr_cnt;
        access(1, 32'h0000_0109, 32'hDEAD_BEEF, rd);
        chk("R5 one write per store", wr_cnt - w0, 1);
        chk("R5 store hit no reads", rd_cnt - r0, 0);
        chk("R5 memory updated", gold(32'h108), 32'hDEAD_BEEF);
        access(0, 32'h0000_0108, 0, rd);
        chk("R5 cached store value", rd, 32'hDEAD_BEEF);
    endtask

    task automatic t_store_miss();
        logic [31:0] rd; int r0 = rd_cnt, w0 = wr_cnt;
        access(1, 32'h0000_0358, 32'h1234_5678, rd);
        chk("R6 store miss refills", rd_cnt - r0, 4);
        chk("R6 store miss writes once", wr_cnt - w0, 1);
        chk("R6 memory holds store", gold(32'h358), 32'h1234_5678);
        r0 = rd_cnt;
        access(0, 32'h0000_0350, 0, rd);
        chk("R6 neighbour word from memory", rd, gold(32'h350));
        access(0, 32'h0000_0358, 0, rd);
        chk("R6 merged word", rd, 32'h1234_5678);
        chk("R6 line now resident", rd_cnt - r0, 0);
    endtask

    task automatic t_conflict();
        logic [31:0] rd; int r0 = rd_cnt;
        access(0, 32'h0000_0904, 0, rd);
        chk("R2 same index other tag misses", rd_cnt - r0, 4);
        chk("R2 conflict data", rd, gold(32'h904));
        r0 = rd_cnt;
        access(0, 32'h0000_0104, 0, rd);
        chk("R2 evicted line refetched", rd_cnt - r0, 4);
        chk("R2 evicted line data", rd, gold(32'h104));
    endtask

    task automatic t_parity();
        logic [31:0] rd; int r0;
        inject(4'd0, 2'd1, 5'd7);
        r0 = rd_cnt;
        access(0, 32'h0000_0104, 0, rd);
        exp_err++;
        chk("R7 corrupted word recovered", rd, gold(32'h104));
        chk("R7 parity miss refills", rd_cnt - r0, 4);
        chk("R8 error counted", {24'b0, err_count}, exp_err);
        r0 = rd_cnt;
        access(0, 32'h0000_0104, 0, rd);
        chk("R7 clean after refill", rd_cnt - r0, 0);
        inject(4'd0, 2'd2, 5'd31);
        r0 = rd_cnt;
        access(0, 32'h0000_0104, 0, rd);
        chk("R7 other word fault ignored", rd_cnt - r0, 0);
        chk("R8 no count on clean word", {24'b0, err_count}, exp_err);
        access(0, 32'h0000_0108, 0, rd);
        exp_err++;
        chk("R7 faulted word refilled", rd, gold(32'h108));
        chk("R8 second error counted", {24'b0, err_count}, exp_err);
    endtask

    task automatic t_saturate();
        logic [31:0] rd;
        for (int i = 0; i < 258; i++) begin
            inject(4'd0, 2'd1, 5'(i % 32));
            access(0, 32'h0000_0104, 0, rd);
        end
        chk("R8 saturates at 255", {24'b0, err_count}, 32'd255);
        chk("R7 data after many faults", rd, gold(32'h104));
    endtask

    task automatic t_slow_mem();
        logic [31:0] rd; int r0 = rd_cnt, w0 = wr_cnt;
        slow = 1'b1;
        access(0, 32'h0000_04A8, 0, rd);
        chk("R10 slow refill data", rd, gold(32'h4A8));
        chk("R10 slow refill beats", rd_cnt - r0, 4);
        access(1, 32'h0000_04A4, 32'h0BAD_F00D, rd);
        chk("R10 slow write-through", gold(32'h4A4), 32'h0BAD_F00D);
        chk("R10 slow single write", wr_cnt - w0, 1);
        slow = 1'b0;
        chk("R9 ready pulse width", ready_max, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_cold_load();
        t_hits();
        t_store_hit();
        t_store_miss();
        t_conflict();
        t_parity();
        t_saturate();
        t_slow_mem();
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    end

endmodule